// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block chooses the next control-store address of a microprogrammed control unit. It owns two registers: the control address register, which points at the microinstruction being executed, and a one-deep return-address register used for microcode subroutines. Each cycle it looks at the current microinstruction's condition code, branch kind and address field. It also looks at three datapath status bits and the instruction opcode. From these it loads the control address register with one of four candidates: the current address plus one, the branch target, the saved return address, or an address derived from the opcode.

The control store, the microoperation decoders and the datapath sit outside this block. The status bits and the opcode arrive as plain inputs. The current address leaves the block as `car`, and the caller uses it to index the control store. After reset the sequencer points at the first word of the instruction fetch routine.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous active-high reset sets the control address to 64 (binary 1000000) and clears the return register to 0 at the next rising edge.
- R2: The 2-bit condition code selects the test: 00 is always true, 01 is `dr_ind`, 10 is `ac_sign`, 11 is `ac_zero`.
- R3: Branch kind 00 (jump) with a true condition loads `br_addr` into the control address.
- R4: Branch kind 00 or 01 with a false condition loads the control address plus one.
- R5: Branch kind 01 (call) with a true condition loads `br_addr` into the control address and the old control address plus one into the return register, in the same edge.
- R6: The return register keeps its value on every edge other than a taken call or reset.
- R7: Branch kind 10 (return) loads the return register into the control address, whatever the condition.
- R8: Branch kind 11 (map) loads the address whose bit 6 is 0, bits 5..2 are `opcode[3:0]`, and bits 1..0 are 0.
- R9: `src_sel` reports the chosen source: 00 increment, 01 branch address, 10 return register, 11 mapped address.
- R10: Incrementing from address 127 gives address 0, with no other indication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_sel | input | 2 | Condition code of the current microinstruction |
| br_type | input | 2 | Branch kind: 00 jump, 01 call, 10 return, 11 map |
| br_addr | input | 7 | Address field of the current microinstruction |
| opcode | input | 4 | Instruction opcode used by map |
| dr_ind | input | 1 | Data-register bit 15 (indirect flag) |
| ac_sign | input | 1 | Accumulator bit 15 (sign) |
| ac_zero | input | 1 | High when the accumulator is zero |
| car | output | 7 | Control address register |
| sbr | output | 7 | Subroutine return register |
| src_sel | output | 2 | Source chosen for the next address |

## Verification
The checker assumes that every microinstruction field, status bit and opcode is driven to a known 0 or 1 on each rising edge outside reset. Its next-cycle properties compare the registers with input values sampled one edge earlier, so they also need those inputs to hold steady through each edge. The stimulus changes inputs only on falling edges and never leaves a field undriven. The bench releases reset only after a full reset cycle, and it applies reset again in the middle of the run to check that the return register is cleared.

// File: rtl/useq_pkg.sv
package useq_pkg;

   // Branch kind carried in the microinstruction
   typedef enum logic [1:0] {
      BR_JUMP = 2'b00,
      BR_CALL = 2'b01,
      BR_RET  = 2'b10,
      BR_MAP  = 2'b11
   } br_kind_e;

   // Next-address source; encoding is visible on the src_sel port
   typedef enum logic [1:0] {
      SRC_INC    = 2'b00,
      SRC_BRANCH = 2'b01,
      SRC_RETURN = 2'b10,
      SRC_MAP    = 2'b11
   } src_e;

   // Condition code positions in the condition vector
   typedef enum logic [1:0] {
      CND_ALWAYS = 2'b00,
      CND_IND    = 2'b01,
      CND_SIGN   = 2'b10,
      CND_ZERO   = 2'b11
   } cond_e;

endpackage

// File: rtl/useq_cond_mux.sv
// Selects one condition bit out of a vector indexed by the condition code.
module useq_cond_mux #(
   parameter int SEL_W = 2
) (
   input  logic [SEL_W-1:0]      sel,
   input  logic [(1<<SEL_W)-1:0] cond_vec,
   output logic                  cond_true
);
   localparam int NUM_COND = 1 << SEL_W;

   logic [NUM_COND-1:0] hit;

   // One AND term per condition; the OR-reduction forms the mux
   for (genvar g = 0; g < NUM_COND; g++) begin : g_term
      assign hit[g] = cond_vec[g] && (sel == SEL_W'(g));
   end

   assign cond_true = |hit;

endmodule

// File: rtl/useq_src_ctl.sv
// Turns branch kind and condition outcome into a source choice and return-register load.
module useq_src_ctl
   import useq_pkg::*;
(
   input  logic [1:0] br_type,
   input  logic       cond_true,
   output logic [1:0] src_sel,
   output logic       sbr_load
);
   br_kind_e kind;
   src_e     src;

   assign kind = br_kind_e'(br_type);

   always_comb begin
      src      = SRC_INC;
      sbr_load = 1'b0;
      unique case (kind)
         BR_JUMP: begin
            src = cond_true ? SRC_BRANCH : SRC_INC;
         end
         BR_CALL: begin
            src      = cond_true ? SRC_BRANCH : SRC_INC;
            sbr_load = cond_true;
         end
         BR_RET:  src = SRC_RETURN;
         BR_MAP:  src = SRC_MAP;
         default: src = SRC_INC;
      endcase
   end

   assign src_sel = src;

endmodule

// File: rtl/useq_addr_mux.sv
// Builds the four address candidates and picks one.
module useq_addr_mux
   import useq_pkg::*;
#(
   parameter int ADDR_W    = 7,
   parameter int OPC_W     = 4,
   parameter int MAP_SHIFT = 2
) (
   input  logic [ADDR_W-1:0] car,
   input  logic [ADDR_W-1:0] br_addr,
   input  logic [ADDR_W-1:0] sbr,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [1:0]        src_sel,
   output logic [ADDR_W-1:0] inc_addr,
   output logic [ADDR_W-1:0] next_addr
);
   localparam int MAP_TOP = MAP_SHIFT + OPC_W;

   logic [ADDR_W-1:0] map_addr;

   // Wraps modulo 2**ADDR_W by width truncation
   assign inc_addr = car + ADDR_W'(1);

   // Opcode placed at bits MAP_TOP-1..MAP_SHIFT; every other bit cleared
   for (genvar b = 0; b < ADDR_W; b++) begin : g_map
      if (b >= MAP_SHIFT && b < MAP_TOP) begin : g_opc
         assign map_addr[b] = opcode[b-MAP_SHIFT];
      end else begin : g_zero
         assign map_addr[b] = 1'b0;
      end
   end

   always_comb begin
      unique case (src_e'(src_sel))
         SRC_INC:    next_addr = inc_addr;
         SRC_BRANCH: next_addr = br_addr;
         SRC_RETURN: next_addr = sbr;
         SRC_MAP:    next_addr = map_addr;
         default:    next_addr = inc_addr;
      endcase
   end

endmodule

// File: rtl/useq_sequencer.sv
// Microprogram next-address sequencer: control address and return registers.
module useq_sequencer
   import useq_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int OPC_W      = 4,
   parameter int MAP_SHIFT  = 2,
   parameter int RESET_ADDR = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        cond_sel,
   input  logic [1:0]        br_type,
   input  logic [ADDR_W-1:0] br_addr,
   input  logic [OPC_W-1:0]  opcode,
   input  logic              dr_ind,
   input  logic              ac_sign,
   input  logic              ac_zero,
   output logic [ADDR_W-1:0] car,
   output logic [ADDR_W-1:0] sbr,
   output logic [1:0]        src_sel
);
   localparam int COND_SEL_W = 2;
   localparam int NUM_COND   = 1 << COND_SEL_W;
   localparam logic [ADDR_W-1:0] CAR_INIT = ADDR_W'(RESET_ADDR);

   // Elaboration-time parameter checks
   initial begin : p_param_chk
      assert (MAP_SHIFT + OPC_W < ADDR_W)
         else $fatal(1, "mapped field does not fit below the top address bit");
      assert (RESET_ADDR >= 0 && RESET_ADDR < (1 << ADDR_W))
         else $fatal(1, "reset address out of range");
   end

   logic [NUM_COND-1:0] cond_vec;
   logic                cond_true;
   logic                sbr_load;
   logic [ADDR_W-1:0]   inc_addr;
   logic [ADDR_W-1:0]   next_addr;

   always_comb begin
      cond_vec             = '0;
      cond_vec[CND_ALWAYS] = 1'b1;
      cond_vec[CND_IND]    = dr_ind;
      cond_vec[CND_SIGN]   = ac_sign;
      cond_vec[CND_ZERO]   = ac_zero;
   end

   useq_cond_mux #(
      .SEL_W(COND_SEL_W)
   ) i_cond (
      .sel      (cond_sel),
      .cond_vec (cond_vec),
      .cond_true(cond_true)
   );

   useq_src_ctl i_ctl (
      .br_type  (br_type),
      .cond_true(cond_true),
      .src_sel  (src_sel),
      .sbr_load (sbr_load)
   );

   useq_addr_mux #(
      .ADDR_W   (ADDR_W),
      .OPC_W    (OPC_W),
      .MAP_SHIFT(MAP_SHIFT)
   ) i_amux (
      .car      (car),
      .br_addr  (br_addr),
      .sbr      (sbr),
      .opcode   (opcode),
      .src_sel  (src_sel),
      .inc_addr (inc_addr),
      .next_addr(next_addr)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         car <= CAR_INIT;
         sbr <= '0;
      end else begin
         car <= next_addr;
         if (sbr_load) begin
            sbr <= inc_addr;
         end
      end
   end

endmodule

// File: rtl/useq_sequencer_chk.sv
// Property checker attached to the sequencer through bind.
module useq_sequencer_chk #(
   parameter int ADDR_W     = 7,
   parameter int OPC_W      = 4,
   parameter int MAP_SHIFT  = 2,
   parameter int RESET_ADDR = 64
) (
   input logic              clk,
   input logic              rst,
   input logic [1:0]        cond_sel,
   input logic [1:0]        br_type,
   input logic [ADDR_W-1:0] br_addr,
   input logic [OPC_W-1:0]  opcode,
   input logic              dr_ind,
   input logic              ac_sign,
   input logic              ac_zero,
   input logic [ADDR_W-1:0] car,
   input logic [ADDR_W-1:0] sbr,
   input logic [1:0]        src_sel
);
   localparam int HI_W = ADDR_W - OPC_W - MAP_SHIFT;

   logic cond_now;
   assign cond_now = (cond_sel == 2'b00) ? 1'b1 :
                     (cond_sel == 2'b01) ? dr_ind :
                     (cond_sel == 2'b10) ? ac_sign : ac_zero;

   assert_reset_R1: assert property (@(posedge clk)
      $fell(rst) |-> (car == ADDR_W'(RESET_ADDR)) && (sbr == '0));

   assert_always_R2: assert property (@(posedge clk) disable iff (rst)
      (cond_sel == 2'b00 && br_type == 2'b00) |-> (src_sel == 2'b01));

   assert_jump_R3: assert property (@(posedge clk) disable iff (rst)
      (br_type == 2'b00 && cond_now) |=> (car == $past(br_addr)));

   assert_incr_R4: assert property (@(posedge clk) disable iff (rst)
      (br_type[1] == 1'b0 && !cond_now) |=> (car == $past(car) + ADDR_W'(1)));

   assert_call_R5: assert property (@(posedge clk) disable iff (rst)
      (br_type == 2'b01 && cond_now) |=>
         (sbr == $past(car) + ADDR_W'(1)) && (car == $past(br_addr)));

   assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !(br_type == 2'b01 && cond_now) |=> $stable(sbr));

   assert_return_R7: assert property (@(posedge clk) disable iff (rst)
      (br_type == 2'b10) |=> (car == $past(sbr)));

   assert_map_R8: assert property (@(posedge clk) disable iff (rst)
      (br_type == 2'b11) |=>
         (car == {{HI_W{1'b0}}, $past(opcode), {MAP_SHIFT{1'b0}}}));

   assert_source_R9: assert property (@(posedge clk) disable iff (rst)
      br_type[1] |-> (src_sel == br_type));

   assert_wrap_R10: assert property (@(posedge clk) disable iff (rst)
      (src_sel == 2'b00 && car == '1) |=> (car == '0));

endmodule

bind useq_sequencer useq_sequencer_chk #(
   .ADDR_W    (ADDR_W),
   .OPC_W     (OPC_W),
   .MAP_SHIFT (MAP_SHIFT),
   .RESET_ADDR(RESET_ADDR)
) i_useq_chk (
   .clk     (clk),
   .rst     (rst),
   .cond_sel(cond_sel),
   .br_type (br_type),
   .br_addr (br_addr),
   .opcode  (opcode),
   .dr_ind  (dr_ind),
   .ac_sign (ac_sign),
   .ac_zero (ac_zero),
   .car     (car),
   .sbr     (sbr),
   .src_sel (src_sel)
);

// File: tb/test_useq_sequencer.sv
`timescale 1ns/1ps
module test_useq_sequencer;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] cond_sel = '0;
   logic [1:0] br_type = '0;
   logic [6:0] br_addr = '0;
   logic [3:0] opcode = '0;
   logic       dr_ind = 1'b0;
   logic       ac_sign = 1'b0;
   logic       ac_zero = 1'b0;
   logic [6:0] car;
   logic [6:0] sbr;
   logic [1:0] src_sel;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   typedef struct {
      logic [6:0] car;
      logic [6:0] sbr;
      string      tag;
   } exp_t;

   exp_t exp_q[$];

   logic [6:0] m_car = 7'd64;
   logic [6:0] m_sbr = 7'd0;

   always #10 clk = ~clk;   // 50 MHz

   useq_sequencer i_useq_sequencer (
      .clk(clk), .rst(rst), .cond_sel(cond_sel), .br_type(br_type),
      .br_addr(br_addr), .opcode(opcode), .dr_ind(dr_ind),
      .ac_sign(ac_sign), .ac_zero(ac_zero),
      .car(car), .sbr(sbr), .src_sel(src_sel)
   );

   // Monitor: compare registers shortly after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (car !== e.car || sbr !== e.sbr) begin
               n_fail++;
               $display("FAIL %s: car=%0d sbr=%0d expected car=%0d sbr=%0d",
                        e.tag, car, sbr, e.car, e.sbr);
            end
         end
      end
   end

   // Watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000 && !done) begin
         n_fail++;
         $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   // Driver: call just after a falling edge (or at time zero)
   task automatic do_reset(input string tag);
      exp_t e;
      rst = 1'b1;
      m_car = 7'd64;
      m_sbr = 7'd0;
      e.car = m_car; e.sbr = m_sbr; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic step(input logic [1:0] cs, input logic [1:0] bt,
                       input logic [6:0] ad, input logic [3:0] opc,
                       input logic di, input logic as, input logic az,
                       input string tag);
      exp_t e;
      logic c;
      logic [1:0] exp_src;
      cond_sel = cs; br_type = bt; br_addr = ad; opcode = opc;
      dr_ind = di; ac_sign = as; ac_zero = az;
      case (cs)
         2'b00: c = 1'b1;
         2'b01: c = di;
         2'b10: c = as;
         default: c = az;
      endcase
      case (bt)
         2'b00, 2'b01: exp_src = c ? 2'b01 : 2'b00;
         2'b10: exp_src = 2'b10;
         default: exp_src = 2'b11;
      endcase
      #1;
      n_checks++;
      if (src_sel !== exp_src) begin
         n_fail++;
         $display("FAIL R9 (%s): src_sel=%0d expected %0d", tag, src_sel, exp_src);
      end
      case (bt)
         2'b00: m_car = c ? ad : m_car + 7'd1;
         2'b01: begin
            if (c) begin
               m_sbr = m_car + 7'd1;
               m_car = ad;
            end else begin
               m_car = m_car + 7'd1;
            end
         end
         2'b10: m_car = m_sbr;
         default: m_car = {1'b0, opc, 2'b00};
      endcase
      e.car = m_car; e.sbr = m_sbr; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
   endtask

   initial begin
      do_reset("R1 reset state");
      // R3 unconditional jump
      step(2'b00, 2'b00, 7'd5, 4'd0, 0, 0, 0, "R3 jump always");
      // R4 / R2 indirect false -> increment
      step(2'b01, 2'b00, 7'd90, 4'd0, 0, 0, 0, "R4 jump not taken");
      // R2 indirect true
      step(2'b01, 2'b00, 7'd20, 4'd0, 1, 0, 0, "R2 indirect taken");
      // R2 sign false then true
      step(2'b10, 2'b00, 7'd33, 4'd0, 1, 0, 1, "R2 sign false");
      step(2'b10, 2'b00, 7'd40, 4'd0, 0, 1, 0, "R2 sign taken");
      // R2 zero true
      step(2'b11, 2'b00, 7'd50, 4'd0, 0, 0, 1, "R2 zero taken");
      // R5 call taken from 50: sbr = 51
      step(2'b00, 2'b01, 7'd67, 4'd0, 0, 0, 0, "R5 call taken");
      // R6 call not taken, sbr holds
      step(2'b11, 2'b01, 7'd10, 4'd0, 0, 0, 0, "R6 call not taken");
      // R6 jump leaves sbr
      step(2'b00, 2'b00, 7'd70, 4'd0, 0, 0, 0, "R6 jump keeps sbr");
      // R7 return with a false condition
      step(2'b11, 2'b10, 7'd99, 4'd0, 0, 0, 0, "R7 return");
      // R8 map 1011 -> 44, 1111 -> 60
      step(2'b00, 2'b11, 7'd127, 4'b1011, 0, 0, 0, "R8 map 1011");
      step(2'b01, 2'b11, 7'd127, 4'b1111, 0, 0, 0, "R8 map 1111");
      // R10 wrap: jump to 127, then increment
      step(2'b00, 2'b00, 7'd127, 4'd0, 0, 0, 0, "R10 reach 127");
      step(2'b10, 2'b00, 7'd3, 4'd0, 0, 0, 0, "R10 wrap to 0");
      // Call from 0, then return
      step(2'b00, 2'b01, 7'd100, 4'd0, 0, 0, 0, "R5 call from 0");
      step(2'b00, 2'b10, 7'd0, 4'd0, 0, 0, 0, "R7 return to 1");
      // Reset again clears sbr
      do_reset("R1 reset mid-run");
      step(2'b11, 2'b00, 7'd8, 4'd0, 0, 0, 0, "R4 increment after reset");
      repeat (3) @(negedge clk);
      n_checks++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard: %0d items left expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule